// File: doc/BRIEF.md
# Eight-Pin Register-Mapped GPIO Expander Core

This core gives a host eight general-purpose pins behind a byte-wide register port made of an address, write data, a write strobe, a read strobe and registered read data. Software chooses each pin's direction, output level, driver tri-state, pull enable and pull polarity. It also reads back the synchronised pin levels. The serial front end that would normally carry these register accesses sits outside this core and drives the strobes directly.

Each input passes through a two-flop synchroniser. A per-pin expected level is held in a register. When an unmasked pin's synchronised level differs from its expected level, a sticky status bit sets. The active-low interrupt line asserts while any status bit is set. It also asserts while the reset-occurred flag is set and at least one pin is unmasked. Reading the status register clears it. Reading the identification register clears the reset-occurred flag. Writing the software-reset bit returns the whole core to its power-on state.

Top module: `gpio_expander_core`

## Requirements
- R1: After reset, reads return these values: direction (0x03) 0x00, output level (0x05) 0x00, tri-state (0x07) 0xFF, expected level (0x09) 0xFF, pull enable (0x0B) 0xFF, pull select (0x0D) 0xFF, mask (0x11) 0xFF and status (0x13) 0x00. At the ports, pin_oe and pin_out are 0x00, pull_en and pull_up are 0xFF, and irq_n is 1.
- R2: The identification register (0x01) reads as follows: bits 7:5 hold the manufacturer code 3'b101, bits 4:2 hold the FW_REV parameter, bit 1 is the reset-occurred flag and bit 0 reads 0. The flag is 1 after reset. A read of 0x01 clears it, so the next read shows bit 1 as 0.
- R3: A write to 0x01 with bit 0 set returns every configuration register and the status register to their R1 values on the next edge, and sets the reset-occurred flag.
- R4: pin_oe[i] is 1 when direction bit i is 1 (1 = output) and tri-state bit i is 0. pin_out[i] equals output-level bit i when pin_oe[i] is 1, and is 0 otherwise.
- R5: pull_en[i] is 1 when pull-enable bit i is 1 and the pin is an input. pull_up[i] is 1 when pull_en[i] is 1 and pull-select bit i is 1 (1 = pull-up).
- R6: A read of 0x0F returns the pin levels delayed by exactly two clock edges of synchronisation (1 = high).
- R7: Status bit i sets when pin i is unmasked (mask bit 0) and its synchronised level differs from expected-level bit i. The bit stays set after the pin returns to its expected level. Masked pins never set a status bit.
- R8: A read of 0x13 returns the status and clears it. A status bit that sets on the same edge as the read is kept for the following read.
- R9: irq_n is 0 exactly when status is non-zero, or when the reset-occurred flag is 1 and the mask is not 0xFF.
- R10: Read data appears on reg_rdata one edge after the read strobe. Unmapped addresses read 0x00. Writes to 0x0F, 0x13 or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_re | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Driven pin levels |
| pin_oe | output | 8 | Per-pin driver enable |
| pull_en | output | 8 | Per-pin pull resistor enable |
| pull_up | output | 8 | Per-pin pull-up select (pull-down when 0 and enabled) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the core with FW_REV = 3'b110 and the default SYNC_STAGES = 2. The revision value differs from zero and from the manufacturer code, so a field placed at the wrong bits of the identification byte shows up as a wrong value. With two synchroniser stages, the bench can time a one-cycle pin pulse so that its status bit sets on the same edge as a status read, which exercises the keep-on-read-clear path. The exact two-edge delay of the input register is checked by reading once just before the new level arrives and once just after.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int GPX_PINS = 8;
  localparam int GPX_AW   = 8;

  typedef logic [GPX_PINS-1:0] pinvec_t;
  typedef logic [GPX_AW-1:0]   addr_t;

  // Offsets are fixed: host software decodes them.
  localparam addr_t ADR_ID    = 8'h01;
  localparam addr_t ADR_DIR   = 8'h03;
  localparam addr_t ADR_OUT   = 8'h05;
  localparam addr_t ADR_HIZ   = 8'h07;
  localparam addr_t ADR_DFLT  = 8'h09;
  localparam addr_t ADR_PEN   = 8'h0B;
  localparam addr_t ADR_PSEL  = 8'h0D;
  localparam addr_t ADR_LEVEL = 8'h0F;
  localparam addr_t ADR_MASK  = 8'h11;
  localparam addr_t ADR_STAT  = 8'h13;

  typedef struct packed {
    pinvec_t dir;
    pinvec_t outv;
    pinvec_t hiz;
    pinvec_t dflt;
    pinvec_t pen;
    pinvec_t psel;
    pinvec_t mask;
  } gpx_cfg_t;

  localparam gpx_cfg_t CFG_RESET = '{
    dir:  '0,
    outv: '0,
    hiz:  '1,
    dflt: '1,
    pen:  '1,
    psel: '1,
    mask: '1
  };
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // Reset to all-high so idle pulled-up pins match the expected level.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  addr_t    wr_addr,
  input  pinvec_t  wr_data,
  input  logic     sw_rst,
  output gpx_cfg_t cfg
);
  gpx_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (sw_rst) begin
      cfg_d = CFG_RESET;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_DIR:  cfg_d.dir  = wr_data;
        ADR_OUT:  cfg_d.outv = wr_data;
        ADR_HIZ:  cfg_d.hiz  = wr_data;
        ADR_DFLT: cfg_d.dflt = wr_data;
        ADR_PEN:  cfg_d.pen  = wr_data;
        ADR_PSEL: cfg_d.psel = wr_data;
        ADR_MASK: cfg_d.mask = wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq
  import gpx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sw_rst,
  input  pinvec_t level,
  input  pinvec_t dflt,
  input  pinvec_t mask,
  input  logic    rd_status,
  input  logic    rd_id,
  output pinvec_t status,
  output logic    rst_flag,
  output logic    irq_n
);
  pinvec_t status_d, status_q, new_set;
  logic    flag_d, flag_q;

  assign new_set = (level ^ dflt) & ~mask;

  always_comb begin
    if (sw_rst) begin
      status_d = '0;
      flag_d   = 1'b1;
    end else begin
      // Read clears old flags; a flag arriving now survives.
      status_d = (rd_status ? '0 : status_q) | new_set;
      flag_d   = rd_id ? 1'b0 : flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      flag_q   <= 1'b1;
    end else begin
      status_q <= status_d;
      flag_q   <= flag_d;
    end
  end

  assign status   = status_q;
  assign rst_flag = flag_q;
  assign irq_n    = ~((|status_q) | (flag_q & ~(&mask)));
endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core
  import gpx_pkg::*;
#(
  parameter logic [2:0] MFR_ID      = 3'b101,
  parameter logic [2:0] FW_REV      = 3'b000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [GPX_AW-1:0]   reg_addr,
  input  logic [GPX_PINS-1:0] reg_wdata,
  input  logic                reg_we,
  input  logic                reg_re,
  output logic [GPX_PINS-1:0] reg_rdata,
  input  logic [GPX_PINS-1:0] pin_in,
  output logic [GPX_PINS-1:0] pin_out,
  output logic [GPX_PINS-1:0] pin_oe,
  output logic [GPX_PINS-1:0] pull_en,
  output logic [GPX_PINS-1:0] pull_up,
  output logic                irq_n
);
  gpx_cfg_t cfg;
  pinvec_t  level, status, rd_mux, rdata_q;
  logic     rst_flag, sw_rst, rd_id, rd_status;

  assign sw_rst    = reg_we && (reg_addr == ADR_ID) && reg_wdata[0];
  assign rd_id     = reg_re && (reg_addr == ADR_ID);
  assign rd_status = reg_re && (reg_addr == ADR_STAT);

  gpx_sync #(.WIDTH(GPX_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_in),
    .d_out (level)
  );

  gpx_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .sw_rst  (sw_rst),
    .cfg     (cfg)
  );

  gpx_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rst    (sw_rst),
    .level     (level),
    .dflt      (cfg.dflt),
    .mask      (cfg.mask),
    .rd_status (rd_status),
    .rd_id     (rd_id),
    .status    (status),
    .rst_flag  (rst_flag),
    .irq_n     (irq_n)
  );

  always_comb begin
    case (reg_addr)
      ADR_ID:    rd_mux = {MFR_ID, FW_REV, rst_flag, 1'b0};
      ADR_DIR:   rd_mux = cfg.dir;
      ADR_OUT:   rd_mux = cfg.outv;
      ADR_HIZ:   rd_mux = cfg.hiz;
      ADR_DFLT:  rd_mux = cfg.dflt;
      ADR_PEN:   rd_mux = cfg.pen;
      ADR_PSEL:  rd_mux = cfg.psel;
      ADR_LEVEL: rd_mux = level;
      ADR_MASK:  rd_mux = cfg.mask;
      ADR_STAT:  rd_mux = status;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_re) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign pin_oe    = cfg.dir & ~cfg.hiz;
  assign pin_out   = cfg.outv & pin_oe;
  assign pull_en   = cfg.pen & ~cfg.dir;
  assign pull_up   = pull_en & cfg.psel;
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
  import gpx_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input addr_t    reg_addr,
  input pinvec_t  reg_wdata,
  input logic     reg_we,
  input logic     reg_re,
  input pinvec_t  reg_rdata,
  input pinvec_t  pin_oe,
  input pinvec_t  pin_out,
  input logic     irq_n,
  input gpx_cfg_t cfg,
  input pinvec_t  status,
  input logic     rst_flag
);
  logic swrst_w, mapped;

  assign swrst_w = reg_we && (reg_addr == ADR_ID) && reg_wdata[0];

  always_comb begin
    case (reg_addr)
      ADR_ID, ADR_DIR, ADR_OUT, ADR_HIZ, ADR_DFLT, ADR_PEN,
      ADR_PSEL, ADR_LEVEL, ADR_MASK, ADR_STAT: mapped = 1'b1;
      default: mapped = 1'b0;
    endcase
  end

  a_r2_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == ADR_ID && !swrst_w) |=> !rst_flag);

  a_r3_swrst_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_w |=> (cfg == CFG_RESET && rst_flag && status == '0));

  a_r4_oe_only_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~cfg.dir) == '0) && ((pin_out & ~pin_oe) == '0));

  a_r7_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & $past(cfg.mask)) == '0);

  a_r8_read_returns_status: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == ADR_STAT && !swrst_w) |=> reg_rdata == $past(status));

  a_r9_status_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (status != '0) |-> !irq_n);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && !mapped) |=> reg_rdata == '0);
endmodule

bind gpio_expander_core gpx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_we    (reg_we),
  .reg_re    (reg_re),
  .reg_rdata (reg_rdata),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .irq_n     (irq_n),
  .cfg       (cfg),
  .status    (status),
  .rst_flag  (rst_flag)
);

// File: tb/sim_gpio_expander_core.sv
module sim_gpio_expander_core;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] TB_FW = 3'b110;

  logic       clk, rst_n, reg_we, reg_re, irq_n;
  logic [7:0] reg_addr, reg_wdata, reg_rdata, pin_in, pin_out, pin_oe, pull_en, pull_up;
  logic       pend;
  int         checks, failures;
  bit         done;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  gpio_expander_core #(.FW_REV(TB_FW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en), .pull_up(pull_up),
    .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: data for a read strobed before an edge is compared at the next falling edge.
  always @(posedge clk) pend <= reg_re;
  always @(negedge clk) begin
    if (pend) begin
      if (sb.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 actual=unexpected-read expected=none");
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(it.tag, reg_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0; reg_wdata = '0;
    pin_in = 8'hFF; rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 pull_en", pull_en, 8'hFF);
    chk("R1 pull_up", pull_up, 8'hFF);
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R1 rdata", reg_rdata, 8'h00);
    rd(8'h03, 8'h00, "R1 dir");
    rd(8'h05, 8'h00, "R1 out");
    rd(8'h07, 8'hFF, "R1 hiz");
    rd(8'h09, 8'hFF, "R1 dflt");
    rd(8'h0B, 8'hFF, "R1 pen");
    rd(8'h0D, 8'hFF, "R1 psel");
    rd(8'h11, 8'hFF, "R1 mask");
    rd(8'h13, 8'h00, "R1 status");

    // R9 reset flag drives irq only once a pin is unmasked
    wr(8'h11, 8'hFE);
    chk("R9 flag unmasked irq", {7'b0, irq_n}, 8'h00);
    wr(8'h11, 8'hFF);
    chk("R9 flag masked irq", {7'b0, irq_n}, 8'h01);

    // R2 identification and flag clear
    rd(8'h01, {3'b101, TB_FW, 1'b1, 1'b0}, "R2 id with flag");
    rd(8'h01, {3'b101, TB_FW, 1'b0, 1'b0}, "R2 id flag cleared");

    // R4 output drive
    wr(8'h03, 8'h0F);
    wr(8'h05, 8'h05);
    chk("R4 oe while hiz", pin_oe, 8'h00);
    wr(8'h07, 8'h03);
    chk("R4 oe", pin_oe, 8'h0C);
    chk("R4 out", pin_out, 8'h04);
    // R5 pulls
    chk("R5 pull_en inputs", pull_en, 8'hF0);
    chk("R5 pull_up inputs", pull_up, 8'hF0);
    wr(8'h0D, 8'h30);
    wr(8'h0B, 8'h70);
    chk("R5 pull_en", pull_en, 8'h70);
    chk("R5 pull_up", pull_up, 8'h30);

    // R10 read-only/unmapped writes and reads
    wr(8'h13, 8'hFF);
    wr(8'h0F, 8'h00);
    wr(8'h20, 8'hAA);
    rd(8'h13, 8'h00, "R10 status write ignored");
    rd(8'h00, 8'h00, "R10 unmapped 00");
    rd(8'h02, 8'h00, "R10 unmapped 02");
    rd(8'h20, 8'h00, "R10 unmapped 20");
    rd(8'h03, 8'h0F, "R10 dir intact");

    // R6 level register and two-edge latency
    pin_in = 8'hA5;
    idle(3);
    rd(8'h0F, 8'hA5, "R6 level");
    pin_in = 8'h3C;
    idle(1);
    rd(8'h0F, 8'hA5, "R6 before second edge");
    rd(8'h0F, 8'h3C, "R6 after second edge");

    // R7 status capture
    wr(8'h09, 8'h3C);
    wr(8'h11, 8'hF0);
    idle(1);
    chk("R9 irq idle", {7'b0, irq_n}, 8'h01);
    pin_in = 8'h3D;
    idle(4);
    chk("R9 irq on status", {7'b0, irq_n}, 8'h00);
    pin_in = 8'h3C;
    idle(4);
    chk("R7 sticky irq", {7'b0, irq_n}, 8'h00);
    rd(8'h13, 8'h01, "R7 status bit0");
    rd(8'h13, 8'h00, "R8 cleared on read");
    chk("R9 irq released", {7'b0, irq_n}, 8'h01);
    pin_in = 8'hBC;
    idle(4);
    rd(8'h13, 8'h00, "R7 masked pin");
    chk("R7 masked irq", {7'b0, irq_n}, 8'h01);
    pin_in = 8'h3C;
    idle(4);

    // R8 set on the same edge as a read is kept
    pin_in = 8'h3E;
    idle(1);
    pin_in = 8'h3C;
    idle(1);
    rd(8'h13, 8'h00, "R8 read at set edge");
    rd(8'h13, 8'h02, "R8 held bit");
    rd(8'h13, 8'h00, "R8 cleared after");

    // R3 software reset
    wr(8'h01, 8'h01);
    chk("R3 pin_oe", pin_oe, 8'h00);
    chk("R3 pull_en", pull_en, 8'hFF);
    chk("R3 irq_n", {7'b0, irq_n}, 8'h01);
    rd(8'h03, 8'h00, "R3 dir");
    rd(8'h07, 8'hFF, "R3 hiz");
    rd(8'h09, 8'hFF, "R3 dflt");
    rd(8'h11, 8'hFF, "R3 mask");
    rd(8'h01, {3'b101, TB_FW, 1'b1, 1'b0}, "R3 flag set, bit0 reads 0");

    idle(2);
    chk("R10 scoreboard drained", 8'(sb.size()), 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule